// File: doc/BRIEF.md
# Bitfield Extract/Insert Unit

This block is a 32-bit datapath slice that serves one bitfield request per cycle. A request either pulls a field out of a source word or writes a field into a base word. For a pull, the field moves down to bit 0 and is then zero-filled or sign-filled above its top bit. A reverse flag can also flip the field end to end, so a full-width field gives a complete 32-bit bit reversal. For a write, the low bits of a second operand replace the selected bits of the base word, and all other base bits are kept.

The field position and size arrive together in one packed control operand. A field that runs past bit 31 is cut off at the word edge. Because a write can place a byte at any position, a write request can build the control word for a later request. The result is registered and returns exactly one cycle after the request, with a matching valid flag.

Top module: `bitfield_unit`

## Requirements
- R1: The control operand carries the field start position in bits [7:0] and the field size in bits [15:8]. Bits [31:16] have no effect on the result.
- R2: With `in_op`=0 (extract), `in_signed`=0 and `in_reverse`=0, the result holds source bits [pos, pos+size) at bits [size-1:0], and every bit above is 0.
- R3: With `in_op`=0 and `in_signed`=1, every result bit above the field is a copy of the field's top bit.
- R4: With `in_op`=0 and `in_reverse`=1, the field's bit order is reversed before it is placed at bit 0. Sign filling then copies the top bit of the reversed field, which is the source bit at the start position. A control value of 0x2000 reverses the whole word.
- R5: With `in_op`=1 (insert), result bits [pos, pos+size) are bits [size-1:0] of `in_src_b`. Every other bit equals `in_src_a`.
- R6: A field size of 0 gives 0 for extract and returns `in_src_a` unchanged for insert.
- R7: Any part of the field above bit 31 is clipped. A start position of 32 or more acts as size 0, and a size larger than the room left above the start position is reduced to that room.
- R8: `out_valid` is `in_valid` delayed by one cycle, and `out_data` carries that request's result. When no request is present, `out_data` holds its previous value.
- R9: While `rst` is high, `out_valid` and `out_data` are cleared to 0 at each clock edge.
- R10: An insert with control 0x0808 places the low byte of `in_src_b` at bit 8 of a start-position value in `in_src_a`. Its result can be used directly as the control operand of a following extract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 1 | 0 = extract, 1 = insert |
| in_signed | input | 1 | Extract: sign-fill above the field |
| in_reverse | input | 1 | Extract: reverse the field's bit order |
| in_src_a | input | 32 | Extract source word, or insert base word |
| in_src_b | input | 32 | Insert data word (its low bits are written) |
| in_ctrl | input | 32 | Packed field start position [7:0] and size [15:8] |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Registered result |

## Verification
The assertions check the timing rules on every cycle: the one-cycle valid delay, the data hold while idle, the reset clear, and the zero-size results for both operations. They also check two field-boundary rules on every cycle: an unsigned extract leaves all bits above the requested size clear, and an insert never changes base bits below the start position. Only the bench scenarios can show the exact field contents. These cover sign filling from the correct bit, the bit order under reversal, clipping at the word edge, the ignored upper control bits, and the chained build of a control word by an insert.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    // Default sizing shared by the unit and its checker
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_FIELD_W = 8;

    // Operation selector carried on in_op
    typedef enum logic {
        BFU_EXTRACT = 1'b0,
        BFU_INSERT  = 1'b1
    } bfu_op_e;

    // Per-request mode flags
    typedef struct packed {
        bfu_op_e op;
        logic    sgn;
        logic    rev;
    } bfu_mode_t;

    // Larger of two integers, used to size intermediate arithmetic
    function automatic int bfu_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfu_ctrl_decode.sv
// Splits the packed control operand and clips the field to the word.
module bfu_ctrl_decode #(
    parameter int DATA_W  = bfu_pkg::DEF_DATA_W,
    parameter int FIELD_W = bfu_pkg::DEF_FIELD_W
) (
    input  logic [2*FIELD_W-1:0]             ctrl_lo,
    output logic [FIELD_W-1:0]               offset,
    output logic [$clog2(DATA_W+1)-1:0]      eff_width,
    output logic [DATA_W-1:0]                low_mask
);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int SPAN_W = bfu_pkg::bfu_max(FIELD_W, CNT_W) + 1;

    logic [SPAN_W-1:0] off_s;
    logic [SPAN_W-1:0] wid_s;
    logic [SPAN_W-1:0] room_s;
    logic [SPAN_W-1:0] eff_s;

    assign offset = ctrl_lo[FIELD_W-1:0];

    always_comb begin
        off_s  = SPAN_W'(ctrl_lo[FIELD_W-1:0]);
        wid_s  = SPAN_W'(ctrl_lo[2*FIELD_W-1:FIELD_W]);
        room_s = '0;
        eff_s  = '0;
        if (off_s < SPAN_W'(DATA_W)) begin
            room_s = SPAN_W'(DATA_W) - off_s;
            eff_s  = (wid_s < room_s) ? wid_s : room_s;
        end
        eff_width = CNT_W'(eff_s);
        low_mask  = ~({DATA_W{1'b1}} << eff_width);
    end

endmodule

// File: rtl/bfu_extract.sv
// Field extraction with optional reversal and sign fill.
module bfu_extract #(
    parameter int DATA_W  = bfu_pkg::DEF_DATA_W,
    parameter int FIELD_W = bfu_pkg::DEF_FIELD_W
) (
    input  logic [DATA_W-1:0]            src,
    input  logic [FIELD_W-1:0]           offset,
    input  logic [$clog2(DATA_W+1)-1:0]  eff_width,
    input  logic [DATA_W-1:0]            low_mask,
    input  logic                         sgn,
    input  logic                         rev,
    output logic [DATA_W-1:0]            result
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] rev_full;
    logic [DATA_W-1:0] rev_field;
    logic [DATA_W-1:0] chosen;
    logic [DATA_W-1:0] top_sel;
    logic [CNT_W-1:0]  rev_shift;
    logic              top_bit;

    // Field aligned to bit 0, bits above its size cleared
    assign field = (src >> offset) & low_mask;

    // Whole-word mirror of the aligned field
    for (genvar g = 0; g < DATA_W; g++) begin : g_mirror
        assign rev_full[g] = field[DATA_W-1-g];
    end

    // Bring the mirrored field back down so it occupies [eff_width-1:0]
    assign rev_shift = CNT_W'(DATA_W) - eff_width;
    assign rev_field = (eff_width == '0) ? '0 : (rev_full >> rev_shift);

    assign chosen = rev ? rev_field : field;

    // One-hot marker on the field's top bit (all zero for an empty field)
    assign top_sel = low_mask ^ (low_mask >> 1);
    assign top_bit = |(chosen & top_sel);

    assign result = chosen | ((sgn && top_bit) ? ~low_mask : '0);

endmodule

// File: rtl/bfu_insert.sv
// Field insertion into a base word.
module bfu_insert #(
    parameter int DATA_W  = bfu_pkg::DEF_DATA_W,
    parameter int FIELD_W = bfu_pkg::DEF_FIELD_W
) (
    input  logic [DATA_W-1:0]   base,
    input  logic [DATA_W-1:0]   ins,
    input  logic [FIELD_W-1:0]  offset,
    input  logic [DATA_W-1:0]   low_mask,
    output logic [DATA_W-1:0]   result
);
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] placed;

    // Clipping is already folded into low_mask; bits shifted past the top fall off
    assign place_mask = low_mask << offset;
    assign placed     = ins << offset;
    assign result     = (base & ~place_mask) | (placed & place_mask);

endmodule

// File: rtl/bitfield_unit.sv
// Top: one bitfield request per cycle, registered result.
module bitfield_unit #(
    parameter int DATA_W  = bfu_pkg::DEF_DATA_W,
    parameter int FIELD_W = bfu_pkg::DEF_FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              in_signed,
    input  logic              in_reverse,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import bfu_pkg::*;

    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int CTRL_W = 2 * FIELD_W;

    bfu_mode_t          mode;
    logic [FIELD_W-1:0] offset;
    logic [CNT_W-1:0]   eff_width;
    logic [DATA_W-1:0]  low_mask;
    logic [DATA_W-1:0]  ext_res;
    logic [DATA_W-1:0]  ins_res;
    logic [DATA_W-1:0]  next_data;
    logic               unused_ctrl_hi;

    assign mode = '{op: bfu_op_e'(in_op), sgn: in_signed, rev: in_reverse};

    // Control bits above the two packed fields carry no meaning
    assign unused_ctrl_hi = ^in_ctrl[DATA_W-1:CTRL_W];

    bfu_ctrl_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_decode (
        .ctrl_lo   (in_ctrl[CTRL_W-1:0]),
        .offset    (offset),
        .eff_width (eff_width),
        .low_mask  (low_mask)
    );

    bfu_extract #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_extract (
        .src       (in_src_a),
        .offset    (offset),
        .eff_width (eff_width),
        .low_mask  (low_mask),
        .sgn       (mode.sgn),
        .rev       (mode.rev),
        .result    (ext_res)
    );

    bfu_insert #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_insert (
        .base     (in_src_a),
        .ins      (in_src_b),
        .offset   (offset),
        .low_mask (low_mask),
        .result   (ins_res)
    );

    always_comb begin
        unique case (mode.op)
            BFU_INSERT:  next_data = ins_res;
            default:     next_data = ext_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
            end
        end
    end

endmodule

// File: rtl/bfu_checker.sv
// Cycle-level properties of bitfield_unit, attached by bind.
module bfu_checker #(
    parameter int DATA_W  = bfu_pkg::DEF_DATA_W,
    parameter int FIELD_W = bfu_pkg::DEF_FIELD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_op,
    input logic              in_signed,
    input logic [DATA_W-1:0] in_src_a,
    input logic [DATA_W-1:0] in_ctrl,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int SPAN_W = FIELD_W + 8;

    logic [FIELD_W-1:0] c_size;
    logic [FIELD_W-1:0] c_pos;

    assign c_pos  = in_ctrl[FIELD_W-1:0];
    assign c_size = in_ctrl[2*FIELD_W-1:FIELD_W];

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R9

    AST_EXTRACT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && c_size == '0) |=> (out_data == '0)); // R6

    AST_INSERT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && c_size == '0) |=> (out_data == $past(in_src_a))); // R6

    AST_UNSIGNED_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && !in_signed && SPAN_W'(c_size) < SPAN_W'(DATA_W))
        |=> ((out_data >> $past(c_size)) == '0)); // R2

    AST_INSERT_LOW_KEEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && SPAN_W'(c_pos) < SPAN_W'(DATA_W))
        |=> (((out_data ^ $past(in_src_a)) & ~({DATA_W{1'b1}} << $past(c_pos))) == '0)); // R5

endmodule

bind bitfield_unit bfu_checker #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_signed (in_signed),
    .in_src_a  (in_src_a),
    .in_ctrl   (in_ctrl),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic        in_signed = 1'b0;
    logic        in_reverse = 1'b0;
    logic [31:0] in_src_a = '0;
    logic [31:0] in_src_b = '0;
    logic [31:0] in_ctrl = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bitfield_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .in_reverse(in_reverse),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_ctrl(in_ctrl),
        .out_valid(out_valid), .out_data(out_data)
    );

    // {op, signed, reverse, src_a, src_b, ctrl, expected}
    localparam int NV = 22;
    localparam logic [130:0] VEC [NV] = '{
        {3'b000, 32'h12345678, 32'h0, 32'h00000804, 32'h00000067}, // R2 size 8 pos 4
        {3'b000, 32'hDEADBEEF, 32'h0, 32'h00001010, 32'h0000DEAD}, // R2 upper half
        {3'b010, 32'h0000F000, 32'h0, 32'h0000040C, 32'hFFFFFFFF}, // R3 negative field
        {3'b010, 32'h00007000, 32'h0, 32'h0000040C, 32'h00000007}, // R3 positive field
        {3'b010, 32'h80000000, 32'h0, 32'h00002000, 32'h80000000}, // R3 full width
        {3'b001, 32'h00000001, 32'h0, 32'h00002000, 32'h80000000}, // R4 full reverse
        {3'b001, 32'h12345678, 32'h0, 32'h00002000, 32'h1E6A2C48}, // R4 full reverse
        {3'b001, 32'h000000B0, 32'h0, 32'h00000404, 32'h0000000D}, // R4 narrow reverse
        {3'b011, 32'h00000010, 32'h0, 32'h00000404, 32'hFFFFFFF8}, // R4 reverse + sign
        {3'b100, 32'hFFFFFFFF, 32'h00000000, 32'h00000808, 32'hFFFF00FF}, // R5 clear byte
        {3'b100, 32'h00000000, 32'hFFFFFFAB, 32'h00000810, 32'h00AB0000}, // R5 only low bits used
        {3'b100, 32'h12345678, 32'h0000000A, 32'h00000400, 32'h1234567A}, // R5 at bit 0
        {3'b010, 32'hFFFFFFFF, 32'h0, 32'h00000005, 32'h00000000}, // R6 empty extract
        {3'b100, 32'h13579BDF, 32'hFFFFFFFF, 32'h00000003, 32'h13579BDF}, // R6 empty insert
        {3'b000, 32'hF0000000, 32'h0, 32'h0000101C, 32'h0000000F}, // R7 clipped unsigned
        {3'b010, 32'hF0000000, 32'h0, 32'h0000101C, 32'hFFFFFFFF}, // R7 clipped signed
        {3'b100, 32'h00000000, 32'hFFFFFFFF, 32'h0000081C, 32'hF0000000}, // R7 clipped insert
        {3'b000, 32'hFFFFFFFF, 32'h0, 32'h00000820, 32'h00000000}, // R7 pos 32 extract
        {3'b100, 32'h11223344, 32'hFFFFFFFF, 32'h00000828, 32'h11223344}, // R7 pos 40 insert
        {3'b000, 32'h12345678, 32'h0, 32'hFFFF0804, 32'h00000067}, // R1 upper ctrl ignored
        {3'b100, 32'h00000000, 32'h00000003, 32'hABCD0202, 32'h0000000C}, // R1 upper ctrl ignored
        {3'b000, 32'h89ABCDEF, 32'h0, 32'h00004000, 32'h89ABCDEF}  // R7 oversize width
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic drive(input logic op, input logic sg, input logic rv,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        in_valid = 1'b1; in_op = op; in_signed = sg; in_reverse = rv;
        in_src_a = a; in_src_b = b; in_ctrl = c;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] last;
        logic [31:0] built;

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R9 out_data in reset", out_data, 32'h0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][130], VEC[i][129], VEC[i][128],
                  VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R8 vector %0d valid", i), {31'b0, out_valid}, 32'h1);
            check($sformatf("vector %0d data", i), out_data, VEC[i][31:0]);
            last = VEC[i][31:0];
        end

        // R8: idle cycle keeps data and drops valid
        @(negedge clk);
        check("R8 idle valid", {31'b0, out_valid}, 32'h0);
        check("R8 idle hold", out_data, last);

        // R8: back-to-back requests, one cycle each
        drive(1'b0, 1'b0, 1'b0, 32'hCAFEBABE, 32'h0, 32'h00000800);
        @(negedge clk);
        check("R8 first of pair", out_data, 32'h000000BE);
        drive(1'b1, 1'b0, 1'b0, 32'h00000000, 32'h00000055, 32'h00000818);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second of pair", out_data, 32'h55000000);
        check("R8 pair valid", {31'b0, out_valid}, 32'h1);

        // R10: build control with insert 0x0808, then use it
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 32'h00000004, 32'h00000008, 32'h00000808);
        @(negedge clk);
        built = out_data;
        check("R10 built control", built, 32'h00000804);
        drive(1'b0, 1'b0, 1'b0, 32'h12345678, 32'h0, built);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 chained extract", out_data, 32'h00000067);

        // R9: reset wins over a request
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h00002000);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset over request valid", {31'b0, out_valid}, 32'h0);
        check("R9 reset over request data", out_data, 32'h0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule